// File: doc/BRIEF.md
# Burst-of-Four Dual-Port Synchronous SRAM Model

This block is a synthesizable stand-in for a quad-data-rate static memory. It has one port for reads and one for writes, and every access is a burst of four data words. A single clock `clk` runs at the beat rate, which is twice the command rate. A two-bit slot counter numbers the edges 0, 1, 2, 3. The edges that follow slot 0 and slot 2 are the rising edges of the true command clock. The edges that follow slot 1 and slot 3 are the rising edges of its complement. The slot is driven out on `slot`, so the host can line its requests up with the counter.

Reads and writes take turns on the shared burst address. A read request is taken only on a slot-0 edge and a write request only on a slot-2 edge, so one read and one write can be in flight at once. Write data comes one command period late and is written into the array beat by beat. Read data leaves 1.5 command periods after the request, with a valid flag.

The array is a set of byte lanes indexed by word address. The four beats of a burst always cover the four consecutive words that begin at the burst's base.

Top module: `qb4_sram`

## Requirements
- R1: When reset is released, `slot` is 0 and `rvalid` and `rdata` are 0. After that, `slot` steps 0, 1, 2, 3, 0 and so on, once per `clk` edge.
- R2: `rd_req` is sampled only on an edge where `slot` was 0, and `wr_req` only on an edge where `slot` was 2. A request held at any other slot starts no burst and changes no word.
- R3: Burst number `b` covers array words 4*b+0 through 4*b+3. Beat i of the burst uses word 4*b+i, and the beats go in rising order.
- R4: For a write taken at edge e, beat i (i from 0 to 3) of `wdata`/`wbe_n` is captured at edge e+2+i. Beats 0 and 2 fall on true-clock edges (slots 0 and 2), and beats 1 and 3 fall on complementary edges.
- R5: `wbe_n` is active low. When bit k is 0, byte k (`wdata` bits 8k+7 down to 8k) of that beat is written. When bit k is 1, that byte of the word keeps its old value.
- R6: For a read taken at edge e, beat i is on `rdata` after edge e+3+i, and `rvalid` is high for exactly those four cycles. Beats 0 and 2 are launched on complementary edges (slots 3 and 1), and beats 1 and 3 on true-clock edges.
- R7: While `rvalid` is low, `rdata` is 0.
- R8: A read beat returns the word with every write beat captured before its launch edge already applied. This includes a write taken in the write slot just before the read whose data is still arriving. A write taken after the read does not affect it.
- R9: Reads on consecutive read slots give an unbroken `rvalid` run, with four beats per read and no gap. Writes on consecutive write slots overlap with them.
- R10: Values on `wdata`/`wbe_n` in cycles that carry no scheduled write beat change no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock, twice the command rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req | input | 1 | Read request, taken on a slot-0 edge |
| wr_req | input | 1 | Write request, taken on a slot-2 edge |
| burst_addr | input | AW-2 (6) | Burst number for the request being taken |
| wdata | input | NB*BW (16) | Write beat data |
| wbe_n | input | NB (2) | Active-low byte enables for the current beat |
| slot | output | 2 | Edge slot counter |
| rdata | output | NB*BW (16) | Read beat data |
| rvalid | output | 1 | High while a read beat is on `rdata` |

## Verification
The riskiest case is a read issued one slot after a write to the same burst. Its later beats have to see data that had not yet arrived when the read was taken. A design that sampled the array at request time, or that forwarded from the wrong stage, would return stale words. The reverse order, a read followed by a write, must still return the old data. A write-back that ran ahead of the data would expose the new words. Back-to-back commands in both directions test the hand-off registers: if a new command overwrote the burst still in progress, the last beats would go to the wrong words. Masked bytes, requests held in the wrong slots, and junk on the data bus outside write beats must all leave the array untouched. A design that got any of these wrong would show it in a later read.

// File: rtl/qb4_pkg.sv
package qb4_pkg;
  // slot values on the edge that takes each command kind
  localparam logic [1:0] SLOT_RD_CMD  = 2'd0;
  localparam logic [1:0] SLOT_WR_CMD  = 2'd2;
  // slot where the command register hands over to the beat register
  localparam logic [1:0] SLOT_RD_MOVE = 2'd3;
  localparam logic [1:0] SLOT_WR_MOVE = 2'd0;

  // read beat launched on the edge ending this slot
  function automatic logic [1:0] rd_beat_of(input logic [1:0] s);
    return s + 2'd1;
  endfunction

  // write beat captured on the edge ending this slot
  function automatic logic [1:0] wr_beat_of(input logic [1:0] s);
    return s;
  endfunction
endpackage

// File: rtl/qb4_lane.sv
module qb4_lane #(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [BW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [BW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [BW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/qb4_wr_seq.sv
module qb4_wr_seq
  import qb4_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    slot,
  input  logic          wr_req,
  input  logic [AW-3:0] burst_addr,
  output logic          cmd_acc,
  output logic          beat_v,
  output logic [AW-1:0] beat_addr
);
  localparam int BA = AW - 2;

  logic          cmd_v, hold_v;
  logic [BA-1:0] cmd_b, hold_b;
  logic [BA-1:0] cur_b;

  assign cmd_acc = wr_req && (slot == SLOT_WR_CMD);

  // late-write buffer: command register, then a beat register for beats 1..3
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v  <= 1'b0;
      cmd_b  <= '0;
      hold_v <= 1'b0;
      hold_b <= '0;
    end else begin
      if (slot == SLOT_WR_CMD) begin
        cmd_v <= wr_req;
        cmd_b <= burst_addr;
      end
      if (slot == SLOT_WR_MOVE) begin
        hold_v <= cmd_v;
        hold_b <= cmd_b;
      end
    end
  end

  assign beat_v    = (slot == SLOT_WR_MOVE) ? cmd_v : hold_v;
  assign cur_b     = (slot == SLOT_WR_MOVE) ? cmd_b : hold_b;
  assign beat_addr = {cur_b, wr_beat_of(slot)};

  // R4
  wr_first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_v && slot == SLOT_WR_MOVE) |-> $past(cmd_acc, 2));
endmodule

// File: rtl/qb4_rd_seq.sv
module qb4_rd_seq
  import qb4_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    slot,
  input  logic          rd_req,
  input  logic [AW-3:0] burst_addr,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_raddr,
  output logic          cmd_acc,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int BA = AW - 2;

  logic          cmd_v, out_v, cur_v;
  logic [BA-1:0] cmd_b, out_b, cur_b;

  assign cmd_acc = rd_req && (slot == SLOT_RD_CMD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_v <= 1'b0;
      cmd_b <= '0;
      out_v <= 1'b0;
      out_b <= '0;
    end else begin
      if (slot == SLOT_RD_CMD) begin
        cmd_v <= rd_req;
        cmd_b <= burst_addr;
      end
      if (slot == SLOT_RD_MOVE) begin
        out_v <= cmd_v;
        out_b <= cmd_b;
      end
    end
  end

  // beat 0 comes straight from the command register, beats 1..3 from the output stage
  assign cur_v     = (slot == SLOT_RD_MOVE) ? cmd_v : out_v;
  assign cur_b     = (slot == SLOT_RD_MOVE) ? cmd_b : out_b;
  assign mem_raddr = {cur_b, rd_beat_of(slot)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= cur_v;
      rdata  <= cur_v ? mem_rdata : '0;
    end
  end

  // R7
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
  import qb4_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 2,
  parameter int BW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_req,
  input  logic               wr_req,
  input  logic [AW-3:0]      burst_addr,
  input  logic [NB*BW-1:0]   wdata,
  input  logic [NB-1:0]      wbe_n,
  output logic [1:0]         slot,
  output logic [NB*BW-1:0]   rdata,
  output logic               rvalid
);
  localparam int DW = NB * BW;

  logic          rd_acc, wr_acc;
  logic          wbeat_v;
  logic [AW-1:0] wbeat_addr, raddr;
  logic [DW-1:0] mem_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= 2'd0;
    else        slot <= slot + 2'd1;
  end

  qb4_wr_seq #(.AW(AW)) i_wr (
    .clk(clk), .rst_n(rst_n), .slot(slot), .wr_req(wr_req),
    .burst_addr(burst_addr), .cmd_acc(wr_acc),
    .beat_v(wbeat_v), .beat_addr(wbeat_addr)
  );

  qb4_rd_seq #(.AW(AW), .DW(DW)) i_rd (
    .clk(clk), .rst_n(rst_n), .slot(slot), .rd_req(rd_req),
    .burst_addr(burst_addr), .mem_rdata(mem_rdata), .mem_raddr(raddr),
    .cmd_acc(rd_acc), .rdata(rdata), .rvalid(rvalid)
  );

  for (genvar k = 0; k < NB; k++) begin : g_lane
    qb4_lane #(.AW(AW), .BW(BW)) i_lane (
      .clk(clk),
      .we(wbeat_v && !wbe_n[k]),
      .waddr(wbeat_addr),
      .wdata(wdata[k*BW +: BW]),
      .raddr(raddr),
      .rdata(mem_rdata[k*BW +: BW])
    );
  end

  // R6
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_acc |-> ##4 rvalid);

  // R6
  rv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rvalid) |-> $past(slot) == SLOT_RD_MOVE);

  // R9
  rv_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rvalid) |-> $past(slot) == SLOT_RD_MOVE);
endmodule

// File: tb/test_qb4_sram.sv
`timescale 1ns/1ps
module test_qb4_sram;
  localparam int AW = 8, NB = 2, BW = 8, DW = NB * BW, BA = AW - 2;

  logic clk = 1'b0, rst_n = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
  logic [BA-1:0] burst_addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [NB-1:0] wbe_n = '1;
  logic [1:0]    slot;
  logic [DW-1:0] rdata;
  logic          rvalid;

  qb4_sram #(.AW(AW), .NB(NB), .BW(BW)) i_qb4_sram (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
    .burst_addr(burst_addr), .wdata(wdata), .wbe_n(wbe_n),
    .slot(slot), .rdata(rdata), .rvalid(rvalid)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [1 << AW];
  bit            rs_v [16];
  logic [AW-1:0] rs_a [16];
  bit            ws_v [16];
  logic [AW-1:0] ws_a [16];
  int            cyc = 0;
  logic [1:0]    bslot = 2'd0;

  function automatic logic [AW-1:0] word_of(logic [BA-1:0] b, int i);
    return AW'(b) * AW'(4) + AW'(i);
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d,
                                          logic [NB-1:0] en_n);
    logic [DW-1:0] r = old;
    for (int k = 0; k < NB; k++)
      if (!en_n[k]) r[k*BW +: BW] = d[k*BW +: BW];
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (edge %0d)", req, act, exp, cyc);
    end
  endtask

  // one clk edge: drive, update the model, then check the outputs after the edge
  task automatic step(bit rd, bit wr, logic [BA-1:0] a, bit mask, string tag);
    int idx = cyc % 16;
    bit ev;
    logic [DW-1:0] ed;
    chk(slot == bslot, "R1 slot count", 32'(slot), 32'(bslot));
    rd_req = rd; wr_req = wr; burst_addr = a;
    wdata  = DW'($urandom);
    wbe_n  = mask ? NB'($urandom) : '0;
    ev = rs_v[idx];
    ed = ev ? mdl[rs_a[idx]] : '0;
    if (ws_v[idx]) mdl[ws_a[idx]] = merge(mdl[ws_a[idx]], wdata, wbe_n);
    rs_v[idx] = 1'b0; ws_v[idx] = 1'b0;
    if (bslot == 2'd0 && rd)
      for (int i = 0; i < 4; i++) begin
        rs_v[(cyc + 3 + i) % 16] = 1'b1;
        rs_a[(cyc + 3 + i) % 16] = word_of(a, i);
      end
    if (bslot == 2'd2 && wr)
      for (int i = 0; i < 4; i++) begin
        ws_v[(cyc + 2 + i) % 16] = 1'b1;
        ws_a[(cyc + 2 + i) % 16] = word_of(a, i);
      end
    @(posedge clk);
    @(negedge clk);
    chk(rvalid == ev, "R6 rvalid window", 32'(rvalid), 32'(ev));
    chk(rdata == ed, ev ? tag : "R7 idle rdata", 32'(rdata), 32'(ed));
    cyc++;
    bslot = bslot + 2'd1;
  endtask

  // one command period pair: read slot, junk slot, write slot, junk slot
  task automatic frame(bit rd, logic [BA-1:0] ra, bit wr, logic [BA-1:0] wa,
                       bit mask, bit junk, string tag);
    step(rd, 1'b0, ra, mask, tag);
    step(junk, junk, BA'($urandom), mask, tag);   // R2 off-slot requests
    step(1'b0, wr, wa, mask, tag);
    step(junk, junk, BA'($urandom), mask, tag);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R1: got hung run expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) begin rs_v[i] = 1'b0; ws_v[i] = 1'b0; end
    repeat (3) @(negedge clk);
    chk(slot == 2'd0, "R1 reset slot", 32'(slot), 0);
    chk(rvalid == 1'b0, "R1 reset rvalid", 32'(rvalid), 0);
    chk(rdata == '0, "R1 reset rdata", 32'(rdata), 0);
    rst_n = 1'b1;

    // fill every burst with full-byte writes
    for (int b = 0; b < (1 << BA); b++)
      frame(1'b0, '0, 1'b1, BA'(b), 1'b0, 1'b0, "R4 fill");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R4 fill");

    // R3 beat order, including the top burst
    frame(1'b1, BA'(5), 1'b0, '0, 1'b0, 1'b0, "R3 beat order");
    frame(1'b1, '1, 1'b0, '0, 1'b0, 1'b0, "R3 top burst");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R3 drain");

    // R8 read one slot after a write to the same burst, then read before write
    frame(1'b0, '0, 1'b1, BA'(7), 1'b0, 1'b0, "R8 coherency");
    frame(1'b1, BA'(7), 1'b1, BA'(9), 1'b0, 1'b0, "R8 coherency");
    frame(1'b1, BA'(9), 1'b1, BA'(9), 1'b0, 1'b0, "R8 read before write");
    frame(1'b1, BA'(9), 1'b0, '0, 1'b0, 1'b0, "R8 coherency");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R8 drain");

    // R5 masked writes, R4 beat timing, read back
    frame(1'b0, '0, 1'b1, BA'(3), 1'b1, 1'b0, "R5 byte mask");
    frame(1'b0, '0, 1'b1, BA'(4), 1'b1, 1'b0, "R4 write beat timing");
    frame(1'b1, BA'(3), 1'b0, '0, 1'b1, 1'b0, "R5 byte mask");
    frame(1'b1, BA'(4), 1'b0, '0, 1'b1, 1'b0, "R4 write beat timing");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R5 drain");

    // R2 off-slot requests and R10 junk data, then read back
    for (int j = 0; j < 8; j++)
      frame(1'b0, '0, 1'b0, '0, 1'b1, 1'b1, "R2 off-slot requests");
    for (int j = 0; j < 8; j++)
      frame(1'b1, BA'(j), 1'b0, '0, 1'b1, 1'b0, "R10 junk data ignored");

    // R9 back-to-back reads and writes
    for (int j = 0; j < 6; j++)
      frame(1'b1, BA'(j), 1'b1, BA'(j + 1), 1'b1, 1'b0, "R9 back-to-back");

    // random traffic on a few bursts for heavy overlap
    for (int j = 0; j < 600; j++)
      frame(1'($urandom), BA'($urandom % 6), 1'($urandom), BA'($urandom % 6),
            1'b1, 1'($urandom), "R8 random traffic");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R8 drain");
    frame(1'b0, '0, 1'b0, '0, 1'b0, 1'b0, "R8 drain");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule